// File: doc/BRIEF.md
# Priority Interrupt Entry Controller

This block sits beside a processor's instruction sequencer and decides when, and for which source, the sequencer must leave the running program and enter a service routine. It watches a set of level-sensitive request lines. The lowest-numbered line has the highest priority. A request is taken only at an instruction boundary, and only while the global enable bit is set. A request is eligible only when its priority is strictly higher than the level now in service.

On acceptance the controller runs a fixed entry sequence. It raises a context-save strobe. It then loads the program counter with the routine address (a base plus four times the source number) and acknowledges the chosen line. It records the new service level on a two-entry nesting stack, so a higher-priority source can preempt a routine that is already running. A return strobe starts a restore sequence. This raises a context-restore strobe and pops the stack, which lowers the held-off threshold back to the interrupted level.

The sequencer has four states:
- RUN is normal execution.
- SAVE drives the save strobe.
- VECT drives the program-counter load, the vector and the acknowledge.
- RESTORE drives the restore strobe.

The transitions are:
- RUN goes to SAVE on a boundary with an eligible winner.
- RUN goes to RESTORE on a return while in service.
- SAVE goes to VECT.
- VECT goes to RUN, which pushes the level.
- RESTORE goes to RUN, which pops the level.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset, in_service is 0, active_lvl is 4 (the code for "no level"), and ctx_save, pc_load, ctx_restore and irq_ack are all 0.
- R2: A request is accepted only when insn_done is 1 in the same clock cycle in which an eligible line is high. ctx_save is then 1 in exactly the next cycle. A request held high without insn_done is never taken.
- R3: The cycle after ctx_save, pc_load is 1, vec_addr equals 0x100 + 4 × source number, and irq_ack has only the bit of that source set. In every other cycle irq_ack is 0. When that entry completes, active_lvl equals the source number and in_service is 1.
- R4: When several eligible lines are high, the lowest-numbered one wins (line 0 highest).
- R5: While level L is in service, lines numbered L or above are not accepted. Lines numbered below L preempt the running routine.
- R6: With two levels nested, no request is accepted until a return has been taken.
- R7: If ret_pulse is 1 while in_service is 1, ctx_restore is 1 in the next cycle, and active_lvl then returns to the interrupted level, or to 4 with in_service 0 after the last return. If ret_pulse arrives with nothing in service, it produces no strobe.
- R8: While glob_en is 0, no request is accepted at any boundary.
- R9: When insn_done and ret_pulse arrive together in RUN, only the return is taken. Both are ignored during the SAVE, VECT and RESTORE states.
- R10: Requests are level-sensitive. A line that stays high remains pending across later boundaries until its routine is entered. A line that drops before the boundary is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 4 | Level request lines, bit 0 highest priority |
| glob_en | input | 1 | Global interrupt enable |
| insn_done | input | 1 | Instruction-boundary pulse from the sequencer |
| ret_pulse | input | 1 | Return-from-interrupt strobe |
| ctx_save | output | 1 | Save processor context (SAVE state) |
| ctx_restore | output | 1 | Restore processor context (RESTORE state) |
| pc_load | output | 1 | Load program counter from vec_addr |
| vec_addr | output | 16 | Service routine start address, valid with pc_load |
| irq_ack | output | 4 | One-hot acknowledge of the entered source |
| in_service | output | 1 | At least one routine is active |
| active_lvl | output | 3 | Level being serviced, 4 when none |

## Verification
The bench targets the following corner cases, each with the failure it would catch:
- A request held without a boundary would be taken early by a design that ignores insn_done.
- A same-or-lower request during service would wrongly nest in a design that compares with "less or equal".
- A third request while two levels are stacked would overrun the stack in a design without a full check.
- A boundary and a return in the same cycle would launch an entry in place of the restore in a design with the wrong arbitration.
- Strobes that arrive during SAVE would cause a double entry in a design that samples them mid-sequence.
- A request that drops before the boundary would be entered anyway in a design that latches it as an edge.
- A line that stays pending across a full stack would be lost in a design that clears it on arrival rather than on entry.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SAVE    = 2'd1,
        ST_VECT    = 2'd2,
        ST_RESTORE = 2'd3
    } irqc_state_e;

endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
    parameter int NUM_SRC = 4,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic               en,
    input  logic [LVL_W-1:0]   limit,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);

    logic [NUM_SRC-1:0] elig;

    // A line is eligible only if it outranks the level being serviced.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig[g] = req[g] && (LVL_W'(g) < limit);
    end

    always_comb begin
        win_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

    assign win_valid = en && (|elig);

endmodule

// File: rtl/irqc_nest_stack.sv
module irqc_nest_stack #(
    parameter int DEPTH    = 2,
    parameter int LVL_W    = 3,
    parameter int NONE_LVL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] push_lvl,
    output logic [LVL_W-1:0] top_lvl,
    output logic             empty,
    output logic             full
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [LVL_W-1:0] lvl_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !pop) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && !push) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q[g] <= LVL_W'(NONE_LVL);
            end else if (push && cnt_q == CNT_W'(g)) begin
                lvl_q[g] <= push_lvl;
            end
        end
    end

    always_comb begin
        top_lvl = LVL_W'(NONE_LVL);
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i + 1)) begin
                top_lvl = lvl_q[i];
            end
        end
    end

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    // R6: the sequencer never pushes past the nesting depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7: a restore never pops an empty stack
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
    parameter int          NUM_SRC    = 4,
    parameter int          ADDR_W     = 16,
    parameter int unsigned VEC_BASE   = 'h100,
    parameter int unsigned VEC_STRIDE = 4,
    parameter int          NEST_DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_req,
    input  logic                       glob_en,
    input  logic                       insn_done,
    input  logic                       ret_pulse,
    output logic                       ctx_save,
    output logic                       ctx_restore,
    output logic                       pc_load,
    output logic [ADDR_W-1:0]          vec_addr,
    output logic [NUM_SRC-1:0]         irq_ack,
    output logic                       in_service,
    output logic [$clog2(NUM_SRC+1)-1:0] active_lvl
);

    import irqc_pkg::*;

    localparam int LVL_W = $clog2(NUM_SRC + 1);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    irqc_state_e      state_q, state_d;
    logic [IDX_W-1:0] sel_q;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] top_lvl;
    logic             stk_empty, stk_full;
    logic             push, pop;

    irqc_prio_pick #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req       (irq_req),
        .en        (glob_en && !stk_full),
        .limit     (top_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    irqc_nest_stack #(
        .DEPTH    (NEST_DEPTH),
        .LVL_W    (LVL_W),
        .NONE_LVL (NUM_SRC)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_lvl (LVL_W'(sel_q)),
        .top_lvl  (top_lvl),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    // Next-state decision: return outranks a boundary in the same cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ret_pulse && !stk_empty) begin
                    state_d = ST_RESTORE;
                end else if (insn_done && win_valid) begin
                    state_d = ST_SAVE;
                end
            end
            ST_SAVE:    state_d = ST_VECT;
            ST_VECT:    state_d = ST_RUN;
            ST_RESTORE: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // State register and captured winner.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && state_d == ST_SAVE) begin
                sel_q <= win_idx;
            end
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        ctx_save    = 1'b0;
        ctx_restore = 1'b0;
        pc_load     = 1'b0;
        irq_ack     = '0;
        vec_addr    = '0;
        push        = 1'b0;
        pop         = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_SAVE: ctx_save = 1'b1;
            ST_VECT: begin
                pc_load  = 1'b1;
                push     = 1'b1;
                irq_ack  = NUM_SRC'(1) << sel_q;
                vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(sel_q) * ADDR_W'(VEC_STRIDE);
            end
            ST_RESTORE: begin
                ctx_restore = 1'b1;
                pop         = 1'b1;
            end
            default: ;
        endcase
    end

    assign in_service = !stk_empty;
    assign active_lvl = top_lvl;

    // R2: an entry starts only from an enabled boundary
    p_entry_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_save |-> $past(insn_done && glob_en));

    // R2: the save strobe is always followed by the vector load
    p_save_then_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_save |=> pc_load);

    // R3: exactly one acknowledge with the vector, none otherwise
    p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> ($countones(irq_ack) == 1));
    p_ack_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_load |-> (irq_ack == '0));

    // R4: the winner is a line that is actually requesting
    p_winner_real_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((irq_req & (NUM_SRC'(1) << win_idx)) != '0));

    // R5: every entry raises the priority in service
    p_entry_raises_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> (active_lvl < $past(active_lvl)));

    // R7: a restore happens only with a routine in service
    p_restore_in_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_restore |-> $past(in_service));

endmodule

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_req = '0;
    logic        glob_en = 1'b0;
    logic        insn_done = 1'b0;
    logic        ret_pulse = 1'b0;
    logic        ctx_save, ctx_restore, pc_load, in_service;
    logic [15:0] vec_addr;
    logic [3:0]  irq_ack;
    logic [2:0]  active_lvl;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // scoreboard: kind 0 = save, 1 = vector, 2 = restore
    int    kind_q[$];
    int    addr_q[$];
    int    ack_q[$];
    string req_q[$];

    always #4 clk = ~clk;

    irq_entry_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .glob_en     (glob_en),
        .insn_done   (insn_done),
        .ret_pulse   (ret_pulse),
        .ctx_save    (ctx_save),
        .ctx_restore (ctx_restore),
        .pc_load     (pc_load),
        .vec_addr    (vec_addr),
        .irq_ack     (irq_ack),
        .in_service  (in_service),
        .active_lvl  (active_lvl)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_entry(input int src, input string req);
        kind_q.push_back(0); addr_q.push_back(0);             ack_q.push_back(0);
        req_q.push_back(req);
        kind_q.push_back(1); addr_q.push_back('h100 + 4 * src); ack_q.push_back(1 << src);
        req_q.push_back(req);
    endtask

    task automatic expect_restore(input string req);
        kind_q.push_back(2); addr_q.push_back(0); ack_q.push_back(0);
        req_q.push_back(req);
    endtask

    task automatic pulse_boundary();
        insn_done = 1'b1;
        tick(1);
        insn_done = 1'b0;
    endtask

    task automatic pulse_ret();
        ret_pulse = 1'b1;
        tick(1);
        ret_pulse = 1'b0;
    endtask

    task automatic settle(input string req);
        tick(5);
        chk(kind_q.size() == 0, req, "scoreboard drained", kind_q.size(), 0);
    endtask

    task automatic chk_lvl(input int lvl, input string req);
        chk(int'(active_lvl) == lvl, req, "active_lvl", int'(active_lvl), lvl);
        chk(in_service == (lvl != 4), req, "in_service", int'(in_service), int'(lvl != 4));
    endtask

    // Monitor: pops expected strobes as the design produces them.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!pc_load && irq_ack != '0) begin
                chk(1'b0, "R3", "stray irq_ack", int'(irq_ack), 0);
            end
            if (ctx_save || pc_load || ctx_restore) begin
                int k;
                k = ctx_save ? 0 : (pc_load ? 1 : 2);
                if (kind_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected strobe kind", k, -1);
                end else begin
                    int    ek, ea, eb;
                    string er;
                    ek = kind_q.pop_front();
                    ea = addr_q.pop_front();
                    eb = ack_q.pop_front();
                    er = req_q.pop_front();
                    chk(k == ek, er, "strobe kind", k, ek);
                    if (k == 1 && ek == 1) begin
                        chk(int'(vec_addr) == ea, er, "vec_addr", int'(vec_addr), ea);
                        chk(int'(irq_ack) == eb, er, "irq_ack", int'(irq_ack), eb);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1: reset state
        chk_lvl(4, "R1");
        chk({ctx_save, pc_load, ctx_restore} == 3'b000, "R1", "strobes idle",
            int'({ctx_save, pc_load, ctx_restore}), 0);
        chk(irq_ack == '0, "R1", "irq_ack idle", int'(irq_ack), 0);
        rst_n = 1'b1;
        tick(2);

        // R8: disabled, a boundary takes nothing
        cur_req = "R8";
        irq_req = 4'b0010;
        pulse_boundary();
        settle("R8");
        chk_lvl(4, "R8");

        // R2: enabled but no boundary, nothing taken
        cur_req = "R2";
        glob_en = 1'b1;
        irq_req = 4'b0100;
        tick(4);
        settle("R2");
        chk_lvl(4, "R2");

        // R3: enter source 2
        cur_req = "R3";
        expect_entry(2, "R3");
        pulse_boundary();
        settle("R3");
        chk_lvl(2, "R3");
        irq_req = 4'b0000;

        // R5: lower priority held off
        cur_req = "R5";
        irq_req = 4'b1000;
        pulse_boundary();
        settle("R5");
        chk_lvl(2, "R5");

        // R5: higher priority preempts
        irq_req = 4'b1010;
        expect_entry(1, "R5");
        pulse_boundary();
        settle("R5");
        chk_lvl(1, "R5");
        irq_req = 4'b1000;

        // R6: stack full, line 0 not accepted
        cur_req = "R6";
        irq_req = 4'b1001;
        pulse_boundary();
        settle("R6");
        chk_lvl(1, "R6");

        // R9: boundary and return together, return wins
        cur_req = "R9";
        expect_restore("R9");
        insn_done = 1'b1;
        ret_pulse = 1'b1;
        tick(1);
        insn_done = 1'b0;
        ret_pulse = 1'b0;
        settle("R9");
        chk_lvl(2, "R9");

        // R10: line 0 stayed pending, taken now
        cur_req = "R10";
        expect_entry(0, "R10");
        pulse_boundary();
        settle("R10");
        chk_lvl(0, "R10");
        irq_req = 4'b1000;

        // R7: unwind both levels, then a stray return
        cur_req = "R7";
        expect_restore("R7");
        pulse_ret();
        settle("R7");
        chk_lvl(2, "R7");
        expect_restore("R7");
        pulse_ret();
        settle("R7");
        chk_lvl(4, "R7");
        pulse_ret();
        settle("R7");
        chk_lvl(4, "R7");

        // R10: line 3 held through everything, taken now
        cur_req = "R10";
        expect_entry(3, "R10");
        pulse_boundary();
        settle("R10");
        chk_lvl(3, "R10");
        irq_req = 4'b0000;
        expect_restore("R10");
        pulse_ret();
        settle("R10");
        chk_lvl(4, "R10");

        // R10: a line dropped before the boundary is not taken
        irq_req = 4'b0010;
        tick(1);
        irq_req = 4'b0000;
        pulse_boundary();
        settle("R10");
        chk_lvl(4, "R10");

        // R9: strobes during SAVE are ignored
        cur_req = "R9";
        irq_req = 4'b0100;
        expect_entry(2, "R9");
        pulse_boundary();
        insn_done = 1'b1;
        ret_pulse = 1'b1;
        tick(1);
        insn_done = 1'b0;
        ret_pulse = 1'b0;
        settle("R9");
        chk_lvl(2, "R9");
        irq_req = 4'b0000;
        expect_restore("R9");
        pulse_ret();
        settle("R9");
        chk_lvl(4, "R9");

        // R4: several lines at once, lowest number wins
        cur_req = "R4";
        irq_req = 4'b1110;
        expect_entry(1, "R4");
        pulse_boundary();
        settle("R4");
        chk_lvl(1, "R4");
        irq_req = 4'b1100;

        // R8: enable cleared while servicing, line 0 not taken
        cur_req = "R8";
        glob_en = 1'b0;
        irq_req = 4'b1101;
        pulse_boundary();
        settle("R8");
        chk_lvl(1, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule